// File: doc/BRIEF.md
# Guarded decoder configuration register bank

This block is an AXI4-Lite slave that holds the static configuration for up to four video decoder instances. For each instance it provides a soft-reset bit, a secure/non-secure select bit, and three stream-ID values: one for decoder engine 0, one for decoder engine 1 and one for the embedded microcontroller. All of these values leave the block as plain output ports. The block also has a read-only version word and a read-only decoder-enable status word whose value comes from an input port.

A guard gates the whole space. After reset the bank is sealed. While it is sealed, every read returns zero and every write to a configuration register is dropped. Software opens the bank by writing the key 32'h7766DF77 to the guard word at offset 0x4, with all four byte strobes set. Writing zero to the same word seals the bank again. The guard word itself is always writable, so software can always open the bank. Reads of the guard word return zero.

Top module: `dec_cfg_bank`

## Requirements
- R1: After reset the bank is sealed, and soft_rst_o, secure_o and sid_o are all zero.
- R2: A write of 32'h7766DF77 to offset 0x4 with WSTRB 4'hF opens the bank. A write of 32'h0 to offset 0x4 with WSTRB 4'hF seals it. Any other value, or any write with a byte strobe cleared, leaves the guard state unchanged.
- R3: While the bank is sealed, every read returns 32'h0 and writes to any offset other than 0x4 change no register.
- R4: Writes to offset 0x4 are accepted whether the bank is sealed or open. A read of offset 0x4 always returns 32'h0.
- R5: While the bank is open, offset 0x0 reads 32'h05, with the major revision in bits 7:4 (0) and the minor revision in bits 3:0 (5). Writes to offset 0x0 have no effect.
- R6: Offset 0x8 is read/write. Bit n drives soft_rst_o[n] for instance n, and bits 31:4 read as zero.
- R7: Offset 0xC is read/write. Bit n drives secure_o[n] for instance n, and bits 31:4 read as zero.
- R8: Stream-ID register k = 3*instance + unit, where unit 0 is decoder 0, unit 1 is decoder 1 and unit 2 is the microcontroller. Registers k = 0 to 10 sit at offset 0x10 + 4*k, and register k = 11 sits at offset 0x4C. Each is 10 bits wide, drives sid_o[10*k+9:10*k], and reads zero in bits 31:10.
- R9: While the bank is open, offset 0x41004 reads dec_en_i in bits 3:0 (1 = enabled) and zero above. Writes to this offset have no effect.
- R10: Reads of unmapped offsets (for example 0x3C) return zero. Every response on BRESP and RRESP is OKAY (2'b00).
- R11: Byte lane b of WSTRB gates bits 8b+7:8b of a write. Bits in lanes with a cleared strobe keep their value.
- R12: The write address and write data channels are accepted independently and in either order, with one write outstanding at a time. BVALID is raised only after both channels have been taken, and BVALID and RVALID stay high (with RDATA stable) until their ready inputs are seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awaddr_i | input | 20 | Write address |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Write byte strobes |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| bresp_o | output | 2 | Write response |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| araddr_i | input | 20 | Read address |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| rdata_o | output | 32 | Read data |
| rresp_o | output | 2 | Read response |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Read data ready |
| dec_en_i | input | 4 | Decoder enable status, one bit per instance |
| soft_rst_o | output | 4 | Soft reset, one bit per instance |
| secure_o | output | 4 | Secure select, one bit per instance |
| sid_o | output | 120 | Twelve 10-bit stream IDs, register k in bits 10k+9:10k |

## Verification
The bench targets the guard first. It tries a key write with a partial strobe, a wrong key, and a relock, so a design that compared only some bytes or ignored the strobes would open the bank too early or fail to seal it. It reads the version and status words while the bank is sealed and checks that the values did not reach the outputs while sealed. It hits the stream-ID register at the irregular offset 0x4C and the gap just below it, where an address decoder that assumed an even stride would alias or miss. It writes single byte lanes to a 10-bit register and issues write data before write address, which catches merge errors and a write path that only worked when both channels arrived together.

// File: rtl/dec_cfg_pkg.sv
package dec_cfg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned STRB_W = DATA_W / 8;

  localparam logic [DATA_W-1:0] GUARD_KEY = 32'h7766DF77;

  localparam logic [31:0] OFF_VER    = 32'h0000_0000;
  localparam logic [31:0] OFF_GUARD  = 32'h0000_0004;
  localparam logic [31:0] OFF_SRST   = 32'h0000_0008;
  localparam logic [31:0] OFF_SEC    = 32'h0000_000C;
  localparam logic [31:0] OFF_SID0   = 32'h0000_0010;
  localparam logic [31:0] OFF_STATUS = 32'h0004_1004;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // stream-id k sits on a 4-byte stride except the last one
  function automatic logic [31:0] sid_offset(input int k, input int n_sid,
                                             input logic [31:0] last_off);
    if (k == n_sid - 1) return last_off;
    return OFF_SID0 + 32'(4 * k);
  endfunction
endpackage

// File: rtl/dec_cfg_wr_chan.sv
module dec_cfg_wr_chan #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [STRB_W-1:0] strb_o
);
  logic aw_full, w_full, bvalid_q;

  assign awready_o = !aw_full && !bvalid_q;
  assign wready_o  = !w_full && !bvalid_q;
  assign req_o     = aw_full && w_full;
  assign bvalid_o  = bvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_full  <= 1'b0;
      w_full   <= 1'b0;
      bvalid_q <= 1'b0;
      addr_o   <= '0;
      data_o   <= '0;
      strb_o   <= '0;
    end else begin
      if (awvalid_i && awready_o) begin
        aw_full <= 1'b1;
        addr_o  <= awaddr_i;
      end
      if (wvalid_i && wready_o) begin
        w_full <= 1'b1;
        data_o <= wdata_i;
        strb_o <= wstrb_i;
      end
      if (req_o) begin
        aw_full  <= 1'b0;
        w_full   <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && bready_i) begin
        bvalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dec_cfg_rd_chan.sv
module dec_cfg_rd_chan #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_word_i
);
  logic rvalid_q;

  assign arready_o = !rvalid_q;
  assign rvalid_o  = rvalid_q;
  assign rd_addr_o = araddr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_o  <= '0;
    end else if (arvalid_i && arready_o) begin
      rvalid_q <= 1'b1;
      rdata_o  <= rd_word_i;
    end else if (rvalid_q && rready_i) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dec_cfg_regfile.sv
module dec_cfg_regfile
  import dec_cfg_pkg::*;
#(
  parameter int unsigned NUM_INST     = 4,
  parameter int unsigned UNITS        = 3,
  parameter int unsigned SID_W        = 10,
  parameter int unsigned ADDR_W       = 20,
  parameter logic [3:0]  VER_MAJOR    = 4'd0,
  parameter logic [3:0]  VER_MINOR    = 4'd5,
  parameter logic [31:0] LAST_SID_OFF = 32'h4C,
  localparam int unsigned NUM_SID     = NUM_INST * UNITS
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_req_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [STRB_W-1:0]        wr_strb_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_word_o,
  input  logic [NUM_INST-1:0]      dec_en_i,
  output logic                     unlocked_o,
  output logic [NUM_INST-1:0]      soft_rst_o,
  output logic [NUM_INST-1:0]      secure_o,
  output logic [NUM_SID*SID_W-1:0] sid_o
);
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] wbits;
  logic              wr_ok;
  logic [SID_W-1:0]  sid_q [NUM_SID];

  always_comb begin
    for (int b = 0; b < int'(STRB_W); b++) wmask[8*b +: 8] = {8{wr_strb_i[b]}};
  end
  assign wbits = wr_data_i & wmask;
  assign wr_ok = wr_req_i && unlocked_o;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [31:0] off);
    return {{(32-ADDR_W){1'b0}}, a} == off;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_o <= 1'b0;
    end else if (wr_req_i && hit(wr_addr_i, OFF_GUARD) && (&wr_strb_i)) begin
      if (wr_data_i == GUARD_KEY) unlocked_o <= 1'b1;
      else if (wr_data_i == '0)   unlocked_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soft_rst_o <= '0;
      secure_o   <= '0;
    end else if (wr_ok) begin
      if (hit(wr_addr_i, OFF_SRST))
        soft_rst_o <= (soft_rst_o & ~wmask[NUM_INST-1:0]) | wbits[NUM_INST-1:0];
      if (hit(wr_addr_i, OFF_SEC))
        secure_o <= (secure_o & ~wmask[NUM_INST-1:0]) | wbits[NUM_INST-1:0];
    end
  end

  for (genvar k = 0; k < NUM_SID; k++) begin : g_sid
    localparam logic [31:0] OFF = sid_offset(k, NUM_SID, LAST_SID_OFF);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sid_q[k] <= '0;
      else if (wr_ok && hit(wr_addr_i, OFF))
        sid_q[k] <= (sid_q[k] & ~wmask[SID_W-1:0]) | wbits[SID_W-1:0];
    end
    assign sid_o[k*SID_W +: SID_W] = sid_q[k];
  end

  always_comb begin
    rd_word_o = '0;
    if (unlocked_o) begin
      if (hit(rd_addr_i, OFF_VER))    rd_word_o[7:0] = {VER_MAJOR, VER_MINOR};
      if (hit(rd_addr_i, OFF_SRST))   rd_word_o[NUM_INST-1:0] = soft_rst_o;
      if (hit(rd_addr_i, OFF_SEC))    rd_word_o[NUM_INST-1:0] = secure_o;
      if (hit(rd_addr_i, OFF_STATUS)) rd_word_o[NUM_INST-1:0] = dec_en_i;
      for (int k = 0; k < int'(NUM_SID); k++)
        if (hit(rd_addr_i, sid_offset(k, NUM_SID, LAST_SID_OFF)))
          rd_word_o[SID_W-1:0] = sid_q[k];
    end
  end
endmodule

// File: rtl/dec_cfg_bank.sv
module dec_cfg_bank
  import dec_cfg_pkg::*;
#(
  parameter int unsigned NUM_INST     = 4,
  parameter int unsigned UNITS        = 3,
  parameter int unsigned SID_W        = 10,
  parameter int unsigned ADDR_W       = 20,
  parameter logic [3:0]  VER_MAJOR    = 4'd0,
  parameter logic [3:0]  VER_MINOR    = 4'd5,
  parameter logic [31:0] LAST_SID_OFF = 32'h4C,
  localparam int unsigned NUM_SID     = NUM_INST * UNITS
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        awaddr_i,
  input  logic                     awvalid_i,
  output logic                     awready_o,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [STRB_W-1:0]        wstrb_i,
  input  logic                     wvalid_i,
  output logic                     wready_o,
  output logic [1:0]               bresp_o,
  output logic                     bvalid_o,
  input  logic                     bready_i,
  input  logic [ADDR_W-1:0]        araddr_i,
  input  logic                     arvalid_i,
  output logic                     arready_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [1:0]               rresp_o,
  output logic                     rvalid_o,
  input  logic                     rready_i,
  input  logic [NUM_INST-1:0]      dec_en_i,
  output logic [NUM_INST-1:0]      soft_rst_o,
  output logic [NUM_INST-1:0]      secure_o,
  output logic [NUM_SID*SID_W-1:0] sid_o
);
  logic              wr_req;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [STRB_W-1:0] wr_strb;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_word;
  logic              unlocked;

  assign bresp_o = RESP_OKAY;
  assign rresp_o = RESP_OKAY;

  dec_cfg_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wr (
    .clk_i, .rst_ni,
    .awaddr_i, .awvalid_i, .awready_o,
    .wdata_i, .wstrb_i, .wvalid_i, .wready_o,
    .bvalid_o, .bready_i,
    .req_o(wr_req), .addr_o(wr_addr), .data_o(wr_data), .strb_o(wr_strb)
  );

  dec_cfg_rd_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd (
    .clk_i, .rst_ni,
    .araddr_i, .arvalid_i, .arready_o,
    .rdata_o, .rvalid_o, .rready_i,
    .rd_addr_o(rd_addr), .rd_word_i(rd_word)
  );

  dec_cfg_regfile #(
    .NUM_INST(NUM_INST), .UNITS(UNITS), .SID_W(SID_W), .ADDR_W(ADDR_W),
    .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR), .LAST_SID_OFF(LAST_SID_OFF)
  ) i_regs (
    .clk_i, .rst_ni,
    .wr_req_i(wr_req), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .rd_addr_i(rd_addr), .rd_word_o(rd_word),
    .dec_en_i, .unlocked_o(unlocked),
    .soft_rst_o, .secure_o, .sid_o
  );
endmodule

module dec_cfg_bank_chk #(
  parameter int unsigned NUM_INST = 4,
  parameter int unsigned SID_BITS = 120
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                unlocked,
  input logic                bvalid_o,
  input logic                bready_i,
  input logic                rvalid_o,
  input logic                rready_i,
  input logic [31:0]         rdata_o,
  input logic                arvalid_i,
  input logic                arready_o,
  input logic [NUM_INST-1:0] soft_rst_o,
  input logic [NUM_INST-1:0] secure_o,
  input logic [SID_BITS-1:0] sid_o
);
  // R3
  sealed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |=> $stable(soft_rst_o) && $stable(secure_o) && $stable(sid_o));
  // R3
  sealed_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arvalid_i && arready_o && !unlocked) |=> (rdata_o == 32'h0));
  // R12
  bvalid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bvalid_o && !bready_i) |=> bvalid_o);
  // R12
  rvalid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rdata_o)));
  // R12
  rvalid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvalid_o) |-> $past(arvalid_i && arready_o));
endmodule

bind dec_cfg_bank dec_cfg_bank_chk #(.NUM_INST(NUM_INST), .SID_BITS(NUM_SID*SID_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .unlocked(unlocked),
  .bvalid_o(bvalid_o), .bready_i(bready_i),
  .rvalid_o(rvalid_o), .rready_i(rready_i), .rdata_o(rdata_o),
  .arvalid_i(arvalid_i), .arready_o(arready_o),
  .soft_rst_o(soft_rst_o), .secure_o(secure_o), .sid_o(sid_o)
);

// File: tb/test_dec_cfg_bank.sv
`timescale 1ns/1ps
module test_dec_cfg_bank;
  localparam logic [31:0] KEY = 32'h7766DF77;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] awaddr_i = '0, araddr_i = '0;
  logic        awvalid_i = 0, wvalid_i = 0, bready_i = 0, arvalid_i = 0, rready_i = 0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  wstrb_i = '0;
  logic [3:0]  dec_en_i = '0;
  logic        awready_o, wready_o, bvalid_o, arready_o, rvalid_o;
  logic [1:0]  bresp_o, rresp_o;
  logic [31:0] rdata_o;
  logic [3:0]  soft_rst_o, secure_o;
  logic [119:0] sid_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  dec_cfg_bank i_dec_cfg_bank (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d, input logic [3:0] s,
                    input int gap_aw = 0, input int gap_w = 0);
    fork
      begin
        repeat (gap_aw) @(negedge clk_i);
        awaddr_i = a; awvalid_i = 1;
        while (!awready_o) @(negedge clk_i);
        @(posedge clk_i); @(negedge clk_i) awvalid_i = 0;
      end
      begin
        repeat (gap_w) @(negedge clk_i);
        wdata_i = d; wstrb_i = s; wvalid_i = 1;
        while (!wready_o) @(negedge clk_i);
        @(posedge clk_i); @(negedge clk_i) wvalid_i = 0;
      end
    join
    bready_i = 1;
    while (!bvalid_o) @(negedge clk_i);
    chk("R10 bresp", 128'(bresp_o), 128'(0));
    @(posedge clk_i); @(negedge clk_i) bready_i = 0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    @(negedge clk_i);
    araddr_i = a; arvalid_i = 1;
    while (!arready_o) @(negedge clk_i);
    @(posedge clk_i); @(negedge clk_i) arvalid_i = 0;
    rready_i = 1;
    while (!rvalid_o) @(negedge clk_i);
    d = rdata_o;
    chk("R10 rresp", 128'(rresp_o), 128'(0));
    @(posedge clk_i); @(negedge clk_i) rready_i = 0;
  endtask

  typedef struct packed {
    logic [19:0] addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{20'h00008, 32'hFFFF_FFFF, 4'hF, 32'h0000_000F},  // R6
    '{20'h0000C, 32'h0000_000A, 4'hF, 32'h0000_000A},  // R7
    '{20'h00010, 32'hFFFF_FFFF, 4'hF, 32'h0000_03FF},  // R8 k0
    '{20'h00038, 32'h0000_0155, 4'hF, 32'h0000_0155},  // R8 k10
    '{20'h0004C, 32'hFFFF_F2AA, 4'hF, 32'h0000_02AA},  // R8 k11
    '{20'h0003C, 32'h0000_0123, 4'hF, 32'h0000_0000},  // R10 unmapped
    '{20'h00000, 32'h0000_00FF, 4'hF, 32'h0000_0005},  // R5 read-only
    '{20'h00004, KEY,           4'hF, 32'h0000_0000}   // R4 guard reads 0
  };

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 soft_rst", 128'(soft_rst_o), 128'(0));
    chk("R1 secure", 128'(secure_o), 128'(0));
    chk("R1 sid", 128'(sid_o), 128'(0));
    rst_ni = 1;
    dec_en_i = 4'b1010;
    // sealed
    rd(20'h0, d);       chk("R3 sealed version", 128'(d), 128'(0));
    rd(20'h41004, d);   chk("R3 sealed status", 128'(d), 128'(0));
    wr(20'h8, 32'hF, 4'hF);
    chk("R3 sealed write", 128'(soft_rst_o), 128'(0));
    rd(20'h4, d);       chk("R4 guard read sealed", 128'(d), 128'(0));
    wr(20'h4, KEY, 4'h7);
    rd(20'h0, d);       chk("R2 partial strobe", 128'(d), 128'(0));
    wr(20'h4, 32'h1234_5678, 4'hF);
    rd(20'h0, d);       chk("R2 wrong key", 128'(d), 128'(0));
    wr(20'h4, KEY, 4'hF);
    rd(20'h0, d);       chk("R2 R5 open version", 128'(d), 128'(5));
    // vector walk
    foreach (VECS[i]) begin
      wr(VECS[i].addr, VECS[i].data, VECS[i].strb);
      rd(VECS[i].addr, d);
      chk($sformatf("R4-table vec %0d", i), 128'(d), 128'(VECS[i].exp));
    end
    chk("R6 soft_rst_o", 128'(soft_rst_o), 128'(4'hF));
    chk("R7 secure_o", 128'(secure_o), 128'(4'hA));
    chk("R8 sid k0", 128'(sid_o[0 +: 10]), 128'(10'h3FF));
    chk("R8 sid k10", 128'(sid_o[100 +: 10]), 128'(10'h155));
    chk("R8 sid k11", 128'(sid_o[110 +: 10]), 128'(10'h2AA));
    chk("R8 sid k9 untouched", 128'(sid_o[90 +: 10]), 128'(0));
    // R11 byte lanes
    wr(20'h14, 32'h0000_03FF, 4'h2);
    chk("R11 lane1 only", 128'(sid_o[10 +: 10]), 128'(10'h300));
    wr(20'h14, 32'h0000_00AB, 4'h1);
    rd(20'h14, d);      chk("R11 lane0 merge", 128'(d), 128'(32'h3AB));
    // R9 status
    rd(20'h41004, d);   chk("R9 status", 128'(d), 128'(4'hA));
    wr(20'h41004, 32'h5, 4'hF);
    dec_en_i = 4'b0110;
    rd(20'h41004, d);   chk("R9 status follows input", 128'(d), 128'(4'h6));
    // R12 data before address
    wr(20'h18, 32'h0000_0111, 4'hF, 3, 0);
    chk("R12 w first", 128'(sid_o[20 +: 10]), 128'(10'h111));
    wr(20'h1C, 32'h0000_0222, 4'hF, 0, 2);
    chk("R12 aw first", 128'(sid_o[30 +: 10]), 128'(10'h222));
    // R2 relock
    wr(20'h4, 32'h0, 4'hF);
    rd(20'h8, d);       chk("R2 relock read", 128'(d), 128'(0));
    wr(20'h8, 32'h0, 4'hF);
    chk("R3 relocked write", 128'(soft_rst_o), 128'(4'hF));
    wr(20'h4, KEY, 4'hF);
    rd(20'h8, d);       chk("R2 reopen keeps value", 128'(d), 128'(4'hF));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule